// File: doc/BRIEF.md
# I2C Target Register File for a Lamp Dimming Controller

This block lets an external I2C master program the settings of a multi-channel lamp dimmer and read them back. It watches the two bus lines with the system clock and finds START and STOP conditions. It answers only to the 7-bit device address 0x6F, so the address byte is 0xDE for a write and 0xDF for a read. The SDA pad is controlled through an active-high pull-down enable: 1 pulls the line low, and 0 lets it float high.

In a write transfer, the first byte after the address loads a register pointer. Each later byte is stored at the pointer, and the pointer then steps up by one. For a read, the master first writes the pointer, then sends a repeated START with the read address. The block returns bytes starting at the pointer and steps the pointer after each byte. The stored settings drive the dimmer and the fault timer directly: master brightness, eight per-channel trims, master enable, channel enables, fault timeout and sync-source select. A status byte from outside the block can also be read.

Top module: `i2c_regfile_top`

## Requirements
- R1: After reset the outputs hold these values: brightness 0x3F, all eight trims 0x00, master enable 0, channel enables 0x00, fault timeout 0x80, sync select 2'b01. `sda_oe` is 0.
- R2: After a START, an address byte of 0xDE or 0xDF is acknowledged. The block holds SDA low during the ninth clock.
- R3: An address byte with any other 7-bit address gets no acknowledge. No later byte is acknowledged and no register changes until the next START. SDA stays released during this time.
- R4: In a write, the first data byte sets the pointer. Each following byte is acknowledged, stored at the pointer, and then the pointer increments.
- R5: A read addressed with 0xDF, including one after a repeated START, returns bytes MSB first. The first byte comes from the pointer, and the pointer increments after each byte.
- R6: When the master does not acknowledge a read byte, the transfer ends. The block releases SDA and waits for the next START.
- R7: Register addresses are: brightness 0x00, trims for channels 1 to 8 at 0x01 to 0x08 (channel k at 0x00+k, output bits [8k-1:8k-8] of `trim_flat`), master enable 0x2A (bit 0 only), channel enables 0x2B (bit n drives channel n+1), fault timeout 0x2C, sync select 0x38 (bits 1:0 only). Unused bits read back as 0.
- R8: Addresses not listed in R7 read as 0x00 and ignore writes. The exception is 0x40, which reads `status_in` and also ignores writes.
- R9: A STOP puts the block back in the idle state. The pointer keeps its value across transfers, so a read with no pointer byte continues from where the last transfer left off. The pointer wraps from 0xFF to 0x00.
- R10: The block changes `sda_oe` only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | Pull SDA low when 1 |
| status_in | input | 8 | Read-only status byte at 0x40 |
| bright | output | 8 | Master brightness |
| trim_flat | output | 64 | Eight per-channel trims, channel 1 in the low byte |
| master_en | output | 1 | Master enable |
| chan_en | output | 8 | Per-channel enables |
| fault_tmo | output | 8 | Fault timeout setting |
| sync_sel | output | 2 | Dimming sync source select |

## Verification
The checks assume that each SCL high and low phase lasts well beyond the three-cycle synchronizer delay. They also assume that SDA moves while SCL is high only to form a START or a STOP, and that the master never signals START or STOP while the target is pulling SDA low. The stimulus keeps to this by holding every bus phase for eight system clocks. It changes master data only in the middle of the SCL low phase. It ends reads with a NACK before sending STOP.

// File: rtl/i2c_regfile_pkg.sv
package i2c_regfile_pkg;

    localparam int DW = 8;
    localparam int NUM_TRIM = 8;
    localparam logic [6:0] DEV_ADDR = 7'h6F;

    localparam logic [7:0] A_BRIGHT = 8'h00;
    localparam logic [7:0] A_TRIM0  = 8'h01;
    localparam logic [7:0] A_MEN    = 8'h2A;
    localparam logic [7:0] A_CHEN   = 8'h2B;
    localparam logic [7:0] A_FTMO   = 8'h2C;
    localparam logic [7:0] A_SYNC   = 8'h38;
    localparam logic [7:0] A_STAT   = 8'h40;

    localparam logic [7:0] RST_BRIGHT = 8'h3F;
    localparam logic [7:0] RST_FTMO   = 8'h80;
    localparam logic [1:0] RST_SYNC   = 2'b01;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ADDR, ST_ACK, ST_PTR, ST_WDATA, ST_RDATA, ST_RACK
    } tgt_state_t;

    typedef enum logic [1:0] {
        NX_PTR, NX_WDATA, NX_RDATA
    } after_ack_t;

    typedef struct packed {
        logic          en;
        logic [DW-1:0] addr;
        logic [DW-1:0] data;
    } wr_req_t;

    function automatic logic addr_is_dev(input logic [7:0] b);
        return b[7:1] == DEV_ADDR;
    endfunction

endpackage

// File: rtl/line_sync.sv
module line_sync #(
    parameter int W = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] lvl,
    output logic [W-1:0] lvl_prev
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        logic              prev_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                chain  <= '1;
                prev_q <= 1'b1;
            end else begin
                chain  <= {chain[STAGES-2:0], din[b]};
                prev_q <= chain[STAGES-1];
            end
        end
        assign lvl[b]      = chain[STAGES-1];
        assign lvl_prev[b] = prev_q;
    end
endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
    import i2c_regfile_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            scl_s,
    input  logic            scl_q,
    input  logic            sda_s,
    input  logic            sda_q,
    input  logic [DW-1:0]   rd_data,
    output logic [DW-1:0]   rd_addr,
    output wr_req_t         wr_req,
    output logic            sda_oe,
    output tgt_state_t      state
);
    localparam int BCW = $clog2(DW + 1);
    localparam logic [BCW-1:0] LAST_RX = BCW'(DW);
    localparam logic [BCW-1:0] LAST_TX = BCW'(DW - 1);

    logic scl_rise, scl_fall, start_ev, stop_ev;
    assign scl_rise = scl_s & ~scl_q;
    assign scl_fall = ~scl_s & scl_q;
    assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;

    logic [DW-1:0]  shreg, txreg, ptr;
    logic [BCW-1:0] bitcnt;
    after_ack_t     nxt;
    logic           mack;

    assign rd_addr = ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            shreg  <= '0;
            txreg  <= '0;
            ptr    <= '0;
            bitcnt <= '0;
            nxt    <= NX_PTR;
            mack   <= 1'b0;
            sda_oe <= 1'b0;
            wr_req <= '0;
        end else begin
            wr_req.en <= 1'b0;
            if (start_ev) begin
                state  <= ST_ADDR;
                bitcnt <= '0;
                sda_oe <= 1'b0;
            end else if (stop_ev) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR, ST_PTR, ST_WDATA: begin
                        if (scl_rise) begin
                            shreg  <= {shreg[DW-2:0], sda_s};
                            bitcnt <= bitcnt + 1'b1;
                        end else if (scl_fall && bitcnt == LAST_RX) begin
                            bitcnt <= '0;
                            if (state == ST_ADDR) begin
                                if (addr_is_dev(shreg)) begin
                                    sda_oe <= 1'b1;
                                    state  <= ST_ACK;
                                    nxt    <= shreg[0] ? NX_RDATA : NX_PTR;
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end else if (state == ST_PTR) begin
                                ptr    <= shreg;
                                sda_oe <= 1'b1;
                                state  <= ST_ACK;
                                nxt    <= NX_WDATA;
                            end else begin
                                wr_req <= '{en: 1'b1, addr: ptr, data: shreg};
                                ptr    <= ptr + 1'b1;
                                sda_oe <= 1'b1;
                                state  <= ST_ACK;
                                nxt    <= NX_WDATA;
                            end
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            bitcnt <= '0;
                            if (nxt == NX_RDATA) begin
                                txreg  <= rd_data;
                                sda_oe <= ~rd_data[DW-1];
                                ptr    <= ptr + 1'b1;
                                state  <= ST_RDATA;
                            end else begin
                                sda_oe <= 1'b0;
                                state  <= (nxt == NX_PTR) ? ST_PTR : ST_WDATA;
                            end
                        end
                    end
                    ST_RDATA: begin
                        if (scl_fall) begin
                            if (bitcnt == LAST_TX) begin
                                bitcnt <= '0;
                                sda_oe <= 1'b0;
                                state  <= ST_RACK;
                            end else begin
                                bitcnt <= bitcnt + 1'b1;
                                txreg  <= {txreg[DW-2:0], 1'b0};
                                sda_oe <= ~txreg[DW-2];
                            end
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise) begin
                            mack <= ~sda_s;
                        end else if (scl_fall) begin
                            if (mack) begin
                                txreg  <= rd_data;
                                sda_oe <= ~rd_data[DW-1];
                                ptr    <= ptr + 1'b1;
                                state  <= ST_RDATA;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    default: begin
                        sda_oe <= 1'b0;
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/dimmer_reg_bank.sv
module dimmer_reg_bank
    import i2c_regfile_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  wr_req_t                wr_req,
    input  logic [DW-1:0]          rd_addr,
    input  logic [DW-1:0]          status_in,
    output logic [DW-1:0]          rd_data,
    output logic [DW-1:0]          bright,
    output logic [NUM_TRIM*DW-1:0] trim_flat,
    output logic                   master_en,
    output logic [DW-1:0]          chan_en,
    output logic [DW-1:0]          fault_tmo,
    output logic [1:0]             sync_sel
);
    logic [DW-1:0] trim_q [NUM_TRIM];

    always_ff @(posedge clk) begin
        if (rst) begin
            bright    <= RST_BRIGHT;
            master_en <= 1'b0;
            chan_en   <= '0;
            fault_tmo <= RST_FTMO;
            sync_sel  <= RST_SYNC;
        end else if (wr_req.en) begin
            case (wr_req.addr)
                A_BRIGHT: bright    <= wr_req.data;
                A_MEN:    master_en <= wr_req.data[0];
                A_CHEN:   chan_en   <= wr_req.data;
                A_FTMO:   fault_tmo <= wr_req.data;
                A_SYNC:   sync_sel  <= wr_req.data[1:0];
                default:  ;
            endcase
        end
    end

    for (genvar k = 0; k < NUM_TRIM; k++) begin : g_trim
        localparam logic [DW-1:0] MY_ADDR = A_TRIM0 + DW'(k);
        always_ff @(posedge clk) begin
            if (rst) begin
                trim_q[k] <= '0;
            end else if (wr_req.en && wr_req.addr == MY_ADDR) begin
                trim_q[k] <= wr_req.data;
            end
        end
        assign trim_flat[k*DW +: DW] = trim_q[k];
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_BRIGHT: rd_data = bright;
            A_MEN:    rd_data = {{(DW-1){1'b0}}, master_en};
            A_CHEN:   rd_data = chan_en;
            A_FTMO:   rd_data = fault_tmo;
            A_SYNC:   rd_data = {{(DW-2){1'b0}}, sync_sel};
            A_STAT:   rd_data = status_in;
            default:  rd_data = '0;
        endcase
        for (int k = 0; k < NUM_TRIM; k++) begin
            if (rd_addr == A_TRIM0 + DW'(k)) rd_data = trim_q[k];
        end
    end
endmodule

// File: rtl/i2c_regfile_top.sv
module i2c_regfile_top
    import i2c_regfile_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        scl_in,
    input  logic        sda_in,
    output logic        sda_oe,
    input  logic [7:0]  status_in,
    output logic [7:0]  bright,
    output logic [63:0] trim_flat,
    output logic        master_en,
    output logic [7:0]  chan_en,
    output logic [7:0]  fault_tmo,
    output logic [1:0]  sync_sel
);
    logic [1:0] lvl, lvl_prev;
    logic       scl_s, scl_q, sda_s, sda_q;
    logic [DW-1:0] rd_data, rd_addr;
    wr_req_t    wr_req;
    tgt_state_t fsm_state;
    logic       wr_en;

    line_sync #(.W(2), .STAGES(2)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .din      ({sda_in, scl_in}),
        .lvl      (lvl),
        .lvl_prev (lvl_prev)
    );

    assign scl_s = lvl[0];
    assign sda_s = lvl[1];
    assign scl_q = lvl_prev[0];
    assign sda_q = lvl_prev[1];
    assign wr_en = wr_req.en;

    i2c_target_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .scl_s   (scl_s),
        .scl_q   (scl_q),
        .sda_s   (sda_s),
        .sda_q   (sda_q),
        .rd_data (rd_data),
        .rd_addr (rd_addr),
        .wr_req  (wr_req),
        .sda_oe  (sda_oe),
        .state   (fsm_state)
    );

    dimmer_reg_bank u_bank (
        .clk       (clk),
        .rst       (rst),
        .wr_req    (wr_req),
        .rd_addr   (rd_addr),
        .status_in (status_in),
        .rd_data   (rd_data),
        .bright    (bright),
        .trim_flat (trim_flat),
        .master_en (master_en),
        .chan_en   (chan_en),
        .fault_tmo (fault_tmo),
        .sync_sel  (sync_sel)
    );
endmodule

// File: rtl/i2c_regfile_chk.sv
module i2c_regfile_chk
    import i2c_regfile_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       scl_s,
    input logic       scl_q,
    input logic       sda_s,
    input logic       sda_q,
    input logic       sda_oe,
    input logic       wr_en,
    input tgt_state_t state
);
    logic start_c, stop_c;
    assign start_c = scl_s && scl_q && sda_q && !sda_s;
    assign stop_c  = scl_s && scl_q && !sda_q && sda_s;

    p_start_addr_r2: assert property (@(posedge clk) disable iff (rst)
        start_c |=> (state == ST_ADDR && !sda_oe));

    p_idle_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> !sda_oe);

    p_write_acked_r4: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (sda_oe && state == ST_ACK));

    p_rack_release_r6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RACK) |-> !sda_oe);

    p_stop_idle_r9: assert property (@(posedge clk) disable iff (rst)
        stop_c |=> (state == ST_IDLE));

    p_oe_scl_low_r10: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> !scl_s);
endmodule

bind i2c_regfile_top i2c_regfile_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .scl_s  (scl_s),
    .scl_q  (scl_q),
    .sda_s  (sda_s),
    .sda_q  (sda_q),
    .sda_oe (sda_oe),
    .wr_en  (wr_en),
    .state  (fsm_state)
);

// File: tb/test_i2c_regfile_top.sv
module test_i2c_regfile_top;
    localparam int Q = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic [7:0] status_in = 8'hA5;
    logic sda_oe, master_en;
    logic [7:0] bright, chan_en, fault_tmo;
    logic [63:0] trim_flat;
    logic [1:0] sync_sel;
    logic sda_line;

    assign sda_line = sda_m & ~sda_oe;

    always #4 clk = ~clk;

    i2c_regfile_top i_i2c_regfile_top (
        .clk(clk), .rst(rst), .scl_in(scl_m), .sda_in(sda_line), .sda_oe(sda_oe),
        .status_in(status_in), .bright(bright), .trim_flat(trim_flat),
        .master_en(master_en), .chan_en(chan_en), .fault_tmo(fault_tmo),
        .sync_sel(sync_sel)
    );

    int total = 0;
    int bad = 0;
    bit busy = 1'b1;
    logic [7:0] mreg [256];
    logic [7:0] mptr = 8'h00;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic void mwrite(input logic [7:0] a, input logic [7:0] d);
        if (a == 8'h00 || (a >= 8'h01 && a <= 8'h08) || a == 8'h2B || a == 8'h2C) mreg[a] = d;
        else if (a == 8'h2A) mreg[a] = {7'b0, d[0]};
        else if (a == 8'h38) mreg[a] = {6'b0, d[1:0]};
    endfunction

    function automatic logic [7:0] mread(input logic [7:0] a);
        return (a == 8'h40) ? status_in : mreg[a];
    endfunction

    // per-clock comparison of register outputs against the model while the bus is quiet (R7)
    int hi_cnt = 0;
    logic prev_oe = 1'b0;
    always @(negedge clk) begin
        if (!rst) begin
            if (!busy) begin
                bit ok;
                ok = (bright == mreg[8'h00]) && (master_en == mreg[8'h2A][0]) &&
                     (chan_en == mreg[8'h2B]) && (fault_tmo == mreg[8'h2C]) &&
                     (sync_sel == mreg[8'h38][1:0]) && !sda_oe;
                for (int k = 0; k < 8; k++) ok = ok && (trim_flat[k*8 +: 8] == mreg[8'(k+1)]);
                chk(ok, "R7 register outputs", int'(bright), int'(mreg[8'h00]));
            end
            if (hi_cnt >= 4) chk(sda_oe == prev_oe, "R10 sda_oe steady while SCL high", sda_oe, prev_oe);
            hi_cnt = scl_m ? hi_cnt + 1 : 0;
            prev_oe = sda_oe;
        end
    end

    task automatic hq();
        repeat (Q) @(posedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; hq();
        scl_m = 1'b1; hq();
        sda_m = 1'b0; hq();
        scl_m = 1'b0; hq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; hq();
        scl_m = 1'b1; hq();
        sda_m = 1'b1; hq(); hq();
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; hq();
            scl_m = 1'b1; hq(); hq();
            scl_m = 1'b0;
        end
        sda_m = 1'b1; hq();
        scl_m = 1'b1; hq();
        @(negedge clk) ack = ~sda_line;
        hq();
        scl_m = 1'b0;
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; hq();
            scl_m = 1'b1; hq();
            @(negedge clk) b[i] = sda_line;
            hq();
            scl_m = 1'b0;
        end
        sda_m = ~give_ack; hq();
        scl_m = 1'b1; hq(); hq();
        scl_m = 1'b0;
    endtask

    task automatic write_burst(input logic [7:0] ptr, input logic [7:0] d [], input string req);
        bit ack;
        busy = 1'b1;
        bus_start();
        send_byte(8'hDE, ack);
        chk(ack, "R2 write address ack", ack, 1);
        send_byte(ptr, ack);
        chk(ack, "R4 pointer ack", ack, 1);
        mptr = ptr;
        foreach (d[i]) begin
            send_byte(d[i], ack);
            chk(ack, req, ack, 1);
            mwrite(mptr, d[i]);
            mptr++;
        end
        bus_stop();
        busy = 1'b0;
        hq();
    endtask

    task automatic read_burst(input bit set_ptr, input logic [7:0] ptr, input int n, input string req);
        bit ack;
        logic [7:0] b;
        busy = 1'b1;
        bus_start();
        if (set_ptr) begin
            send_byte(8'hDE, ack);
            chk(ack, "R2 write address ack", ack, 1);
            send_byte(ptr, ack);
            chk(ack, "R4 pointer ack", ack, 1);
            mptr = ptr;
            bus_start();
        end
        send_byte(8'hDF, ack);
        chk(ack, "R2 read address ack", ack, 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(i != n - 1, b);
            chk(b == mread(mptr), req, b, mread(mptr));
            mptr++;
        end
        hq();
        chk(!sda_oe && sda_line, "R6 SDA released after NACK", sda_oe, 0);
        bus_stop();
        busy = 1'b0;
        hq();
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        bit ack;
        for (int a = 0; a < 256; a++) mreg[a] = 8'h00;
        mreg[8'h00] = 8'h3F;
        mreg[8'h2C] = 8'h80;
        mreg[8'h38] = 8'h01;
        repeat (5) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(bright == 8'h3F && trim_flat == 64'h0 && !master_en && chan_en == 8'h00 &&
            fault_tmo == 8'h80 && sync_sel == 2'b01 && !sda_oe, "R1 reset values", bright, 8'h3F);
        busy = 1'b0;
        hq();

        // R4: burst write across all trims
        write_burst(8'h01, '{8'h11, 8'h22, 8'h33, 8'hF4, 8'h05, 8'hE6, 8'h77, 8'h88}, "R4 trim burst ack");
        // R7: burst write across enables/timeout, plus width masks
        write_burst(8'h2A, '{8'hFF, 8'h5A, 8'h40}, "R7 control burst ack");
        write_burst(8'h38, '{8'hFE}, "R7 sync select ack");
        write_burst(8'h00, '{8'hC3}, "R4 brightness ack");

        // R5: read back with repeated START, crossing into unmapped space (R8)
        read_burst(1'b1, 8'h00, 10, "R5 burst read data");
        read_burst(1'b1, 8'h2A, 3, "R7 masked readback");
        read_burst(1'b1, 8'h38, 1, "R7 sync readback");

        // R8: unmapped and status writes ignored; status readable
        write_burst(8'h10, '{8'h99, 8'h98}, "R8 unmapped write ack");
        write_burst(8'h40, '{8'h00}, "R8 status write ack");
        read_burst(1'b1, 8'h10, 2, "R8 unmapped read zero");
        read_burst(1'b1, 8'h40, 1, "R8 status read");
        status_in = 8'h3C;
        read_burst(1'b1, 8'h40, 1, "R8 status follows input");

        // R9: read with no pointer byte continues from the kept pointer
        read_burst(1'b1, 8'h03, 2, "R5 short read");
        read_burst(1'b0, 8'h00, 3, "R9 pointer kept across transfers");
        // R9: pointer wraps from 0xFF to 0x00
        read_burst(1'b1, 8'hFF, 3, "R9 pointer wrap");

        // R3: wrong device address is ignored
        busy = 1'b1;
        bus_start();
        send_byte(8'hA0, ack);
        chk(!ack, "R3 wrong address no ack", ack, 0);
        send_byte(8'h00, ack);
        chk(!ack, "R3 pointer byte ignored", ack, 0);
        send_byte(8'h12, ack);
        chk(!ack, "R3 data byte ignored", ack, 0);
        bus_stop();
        busy = 1'b0;
        hq();
        read_burst(1'b1, 8'h00, 1, "R3 brightness unchanged");

        // R2: a read address on the wrong device with read bit set also gets no ack
        busy = 1'b1;
        bus_start();
        send_byte(8'hDD, ack);
        chk(!ack, "R3 neighbour address no ack", ack, 0);
        bus_stop();
        busy = 1'b0;
        repeat (20) @(posedge clk);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule